// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken by combining two component predictors. A per-branch predictor holds one 2-bit saturating counter for each slot selected by the branch address. A history-based predictor holds 2-bit counters selected by a shift register of recent branch outcomes. A third table, again one 2-bit saturating counter per address slot, picks which of the two components supplies the final answer.

The fetch side issues a lookup with the branch PC over a valid/ready request channel. One cycle after acceptance, the block returns three bits on a valid/ready response channel: the final direction and each component's own guess. The response holds steady while the consumer keeps `rsp_ready` low. A new request is accepted only when the output register is empty or is being drained in the same cycle. When the branch resolves, the pipeline sends an update carrying the PC, the real outcome and the two component guesses recorded at lookup. The update channel never stalls. A lookup in the same cycle as an update sees the tables as they were before that update.

Top module: `tourney_pred`

## Requirements
- R1: After reset, every direction counter and every chooser counter equals 1, the outcome history is all zeros, `rsp_valid` is 0 and `lk_ready` is 1, so the first lookup returns not-taken for all three outputs.
- R2: A 2-bit counter value of 2 or 3 means taken; 0 or 1 means not taken.
- R3: The per-branch table has 512 counters selected by PC bits 10 down to 2, so PCs that differ only above bit 10 share a slot. Each update moves the slot toward the real outcome (+1 taken, -1 not taken), saturating at 0 and 3.
- R4: The history table has 256 counters selected by the 8-bit outcome history. Each update trains the slot selected by the history value held before that update's shift, with the same saturating rule.
- R5: Each accepted update shifts the history left by one bit and inserts the real outcome (1 = taken) at bit 0.
- R6: A chooser value of 0 or 1 makes the final prediction follow the per-branch component; 2 or 3 makes it follow the history component.
- R7: The chooser slot (PC bits 10:2) changes only when the two recorded component guesses differ. It steps up when the history guess matched the outcome and steps down when the per-branch guess matched, saturating at 0 and 3.
- R8: A request accepted on a clock edge produces `rsp_valid` high right after that edge, computed from the state before any update on the same edge.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response fields and `rsp_valid` hold, and `lk_ready` is low.
- R10: `upd_ready` is always 1, and every cycle with `upd_valid` high applies one update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_pc | input | 32 | Branch address to predict |
| rsp_valid | output | 1 | Prediction response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_taken | output | 1 | Final predicted direction |
| rsp_loc_taken | output | 1 | Per-branch component guess |
| rsp_glb_taken | output | 1 | History component guess |
| upd_valid | input | 1 | Resolved-branch update present |
| upd_ready | output | 1 | Update accepted (always 1) |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome |
| upd_loc_taken | input | 1 | Per-branch guess recorded at lookup |
| upd_glb_taken | input | 1 | History guess recorded at lookup |

## Verification
A branch that is always taken drives the per-branch counters to saturation and shows the chooser staying on that component while both agree. A strictly alternating branch makes the two components disagree, which moves the chooser toward the history component; this separates correct chooser training from training that ignores agreement. Two PCs that differ only above bit 10 show that slots are shared. A long pseudo-random mix of PCs and outcomes, with the response consumer stalling every third cycle, compares all three outputs against a reference model and checks that the back-pressure hold is respected.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_MAX = '1;
  localparam ctr_t CTR_WEAK_NT = ctr_t'(1);

  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    if (up) return (c == CTR_MAX) ? c : c + ctr_t'(1);
    else    return (c == '0) ? c : c - ctr_t'(1);
  endfunction

  function automatic logic ctr_taken(input ctr_t c);
    return c[CTR_W-1];
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter ctr_t INIT = CTR_WEAK_NT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;
  ctr_t mem_q [DEPTH];

  assign rd_ctr = mem_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT;
    end else if (wr_en) begin
      mem_q[wr_idx] <= ctr_step(mem_q[wr_idx], wr_up);
    end
  end
endmodule

// File: rtl/tp_hist.sv
module tp_hist #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[W-2:0], bit_in};
  end
endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
  import tp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int LOC_W = 9,
  parameter int HIST_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  output logic            lk_ready,
  input  logic [PC_W-1:0] lk_pc,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_taken,
  output logic            rsp_loc_taken,
  output logic            rsp_glb_taken,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_loc_taken,
  input  logic            upd_glb_taken
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + LOC_W - 1;

  logic [LOC_W-1:0]  lk_idx, up_idx;
  logic [HIST_W-1:0] hist_q;
  ctr_t loc_ctr, glb_ctr, sel_ctr;
  logic lk_fire, sel_wr;
  logic loc_bit, glb_bit, fin_bit;

  assign lk_idx    = lk_pc[IDX_HI:IDX_LO];
  assign up_idx    = upd_pc[IDX_HI:IDX_LO];
  assign upd_ready = 1'b1;
  assign lk_ready  = !rsp_valid || rsp_ready;
  assign lk_fire   = lk_valid && lk_ready;
  assign sel_wr    = upd_valid && (upd_loc_taken != upd_glb_taken);

  tp_ctr_table #(.IDX_W(LOC_W), .INIT(CTR_WEAK_NT)) u_loc (
    .clk(clk), .rst_n(rst_n), .rd_idx(lk_idx), .rd_ctr(loc_ctr),
    .wr_en(upd_valid), .wr_idx(up_idx), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(HIST_W), .INIT(CTR_WEAK_NT)) u_glb (
    .clk(clk), .rst_n(rst_n), .rd_idx(hist_q), .rd_ctr(glb_ctr),
    .wr_en(upd_valid), .wr_idx(hist_q), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(LOC_W), .INIT(CTR_WEAK_NT)) u_sel (
    .clk(clk), .rst_n(rst_n), .rd_idx(lk_idx), .rd_ctr(sel_ctr),
    .wr_en(sel_wr), .wr_idx(up_idx), .wr_up(upd_glb_taken == upd_taken)
  );

  tp_hist #(.W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(upd_valid), .bit_in(upd_taken), .hist(hist_q)
  );

  always_comb begin
    loc_bit = ctr_taken(loc_ctr);
    glb_bit = ctr_taken(glb_ctr);
    fin_bit = ctr_taken(sel_ctr) ? glb_bit : loc_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_taken     <= 1'b0;
      rsp_loc_taken <= 1'b0;
      rsp_glb_taken <= 1'b0;
    end else if (lk_ready) begin
      rsp_valid <= lk_valid;
      if (lk_fire) begin
        rsp_taken     <= fin_bit;
        rsp_loc_taken <= loc_bit;
        rsp_glb_taken <= glb_bit;
      end
    end
  end
endmodule

// File: rtl/tp_chk.sv
module tp_chk #(
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_taken,
  input logic              rsp_loc_taken,
  input logic              rsp_glb_taken,
  input logic              upd_valid,
  input logic              upd_ready,
  input logic              upd_taken,
  input logic [HIST_W-1:0] hist_q
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_taken) &&
      $stable(rsp_loc_taken) && $stable(rsp_glb_taken));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !lk_ready);

  // R8
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> rsp_valid);

  // R10
  upd_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ready);

  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(upd_taken)});

  // R6
  agree_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_loc_taken == rsp_glb_taken) |-> rsp_taken == rsp_loc_taken);
endmodule

bind tourney_pred tp_chk #(.HIST_W(HIST_W)) u_tp_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_taken(rsp_taken),
  .rsp_loc_taken(rsp_loc_taken), .rsp_glb_taken(rsp_glb_taken),
  .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_taken(upd_taken),
  .hist_q(hist_q)
);

// File: tb/tourney_pred_test.sv
module tourney_pred_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_pc = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_taken, rsp_loc_taken, rsp_glb_taken;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0, upd_loc_taken = 1'b0, upd_glb_taken = 1'b0;

  tourney_pred uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_taken(rsp_taken),
    .rsp_loc_taken(rsp_loc_taken), .rsp_glb_taken(rsp_glb_taken),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_loc_taken(upd_loc_taken), .upd_glb_taken(upd_glb_taken)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit stall_mode = 1'b0;
  int cyc = 0;
  logic [2:0] exp_q[$];

  logic [1:0] m_loc [512];
  logic [1:0] m_glb [256];
  logic [1:0] m_sel [512];
  logic [7:0] m_hist;
  logic       last_loc, last_glb;

  function automatic logic [1:0] step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Monitor: sets consumer ready, pops and compares transfers, checks stalls
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      rsp_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (rsp_valid && !rsp_ready)
        check("R9 lk_ready while stalled", {31'd0, lk_ready}, 32'd0);
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check("R8 unexpected response", 32'd1, 32'd0);
        end else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          check("R6 R7 final", {31'd0, rsp_taken}, {31'd0, e[2]});
          check("R3 local", {31'd0, rsp_loc_taken}, {31'd0, e[1]});
          check("R4 R5 global", {31'd0, rsp_glb_taken}, {31'd0, e[0]});
        end
      end
    end
  end

  task automatic lookup(input logic [31:0] pc);
    logic [8:0] li;
    logic l, g, f, acc;
    li = pc[10:2];
    l = m_loc[li][1];
    g = m_glb[m_hist][1];
    f = m_sel[li][1] ? g : l;
    last_loc = l;
    last_glb = g;
    exp_q.push_back({f, l, g});
    #2;
    lk_pc = pc;
    lk_valid = 1'b1;
    forever begin
      acc = lk_ready;
      @(negedge clk);
      if (acc) break;
      #2;
    end
    check("R8 valid after accept", {31'd0, rsp_valid}, 32'd1);
    lk_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic update(input logic [31:0] pc, input logic t);
    logic [8:0] li;
    li = pc[10:2];
    #2;
    upd_pc = pc;
    upd_taken = t;
    upd_loc_taken = last_loc;
    upd_glb_taken = last_glb;
    upd_valid = 1'b1;
    check("R10 upd_ready", {31'd0, upd_ready}, 32'd1);
    @(negedge clk);
    upd_valid = 1'b0;
    m_loc[li] = step(m_loc[li], t);
    m_glb[m_hist] = step(m_glb[m_hist], t);
    if (last_loc != last_glb) m_sel[li] = step(m_sel[li], last_glb == t);
    m_hist = {m_hist[6:0], t};
  endtask

  task automatic branch(input logic [31:0] pc, input logic t);
    lookup(pc);
    update(pc, t);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check("watchdog", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 512; i++) begin m_loc[i] = 2'd1; m_sel[i] = 2'd1; end
    for (int i = 0; i < 256; i++) m_glb[i] = 2'd1;
    m_hist = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R1: idle outputs after reset
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 lk_ready", {31'd0, lk_ready}, 32'd1);
    @(negedge clk);
    // R1 R2: first lookup returns not-taken everywhere (counters at 1)
    branch(32'h0000_0100, 1'b1);
    // R3: always-taken branch saturates its local counter
    for (int i = 0; i < 6; i++) branch(32'h0000_0100, 1'b1);
    // R3: alias PC shares bits 10:2 with 0x100
    lookup(32'h0000_0900);
    check("R3 alias local taken", {31'd0, last_loc}, 32'd1);
    update(32'h0000_0900, 1'b0);
    // R7: alternating branch makes components disagree
    for (int i = 0; i < 24; i++) branch(32'h0000_0204, i[0]);
    // R9: random mix under consumer stalls
    stall_mode = 1'b1;
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      branch({22'd0, lfsr[3:0], lfsr[9:8], 2'b00} + 32'h0000_0400, lfsr[5] | lfsr[7]);
    end
    stall_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 queue drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule